// File: doc/BRIEF.md
# Per-Pin Interrupt and Wake Event Detector

This block sits behind a bank of general-purpose pins and turns each pin's already-filtered input level into an interrupt and a wake request. A small set of control bits configures each pin independently. These bits choose edge or level sensing and the polarity or edges that count. They also decide whether a detected event may latch the interrupt status, whether a latched status reaches the interrupt line, and whether the event also records a wake request. The statuses stay latched until software clears them with a write-one-to-clear strobe.

The same block also forms the pin's output side. It passes the output value and output enable to the pad. It also returns the sampled input level as a readable pin status while the pin is not driving. The register bus that loads the control bits, and the pad itself, sit outside the block. Summary outputs OR the unmasked interrupts and the wake statuses of all pins for the upstream interrupt controller.

Top module: `gpio_irq_pin_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every interrupt status, wake status, interrupt output, summary output and pin status reads 0.
- R2: Each pin uses a 2-bit polarity field at bits [2i+1:2i] of `act_sel_i`: 00 = low level or falling edge, 01 = high level or rising edge, 10 = both edges, 11 = reserved. The mode bit `trig_level_i[i]` selects level (1) or edge (0) sensing. In edge mode with code 01, a 0-to-1 change of the pin sets the interrupt status at the next clock edge, and the status then stays set.
- R3: In edge mode, code 00 sets the status on a 1-to-0 change, and code 10 sets it on either change. A change of the wrong direction sets nothing.
- R4: In level mode, code 01 sets the status on every clock edge while the pin is high, and code 00 does the same while the pin is low. A clear issued while the level is still active has no effect. The status stays set after the level goes inactive.
- R5: Code 11 never sets either status, in either mode. Code 10 in level mode also sets nothing.
- R6: With `int_en_i[i]` = 0, an event does not set the interrupt status. Enabling the pin later does not recover an event that was missed.
- R7: `irq_o[i]` is the interrupt status gated by `int_unmask_i[i]` (1 = unmasked). Masking does not stop the status from latching. `irq_any_o` is the OR of all `irq_o` bits.
- R8: A 1 on `int_clr_i[i]` clears the interrupt status at the next edge, and a 0 leaves it unchanged. An event in the same cycle as a clear wins, so the status stays set.
- R9: With `wake_en_i[i]` = 1, an event sets the wake status whatever `int_en_i` holds. Only `wake_clr_i[i]` clears it, and an event in the same cycle wins over that clear. `wake_any_o` is the OR of all wake statuses.
- R10: `pad_oe_o` follows `out_en_i`, and `pad_out_o[i]` is `out_val_i[i]` when the pin is enabled and 0 otherwise. `pin_sts_o[i]` shows the pin level sampled at the last edge while output enable is 0, and reads 0 while it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level_i | input | NUM_PINS | Filtered input level of each pin |
| int_en_i | input | NUM_PINS | Allow events to latch the interrupt status |
| int_unmask_i | input | NUM_PINS | 1 lets the latched status drive irq_o |
| trig_level_i | input | NUM_PINS | 1 = level sensing, 0 = edge sensing |
| act_sel_i | input | 2*NUM_PINS | Per-pin polarity/edge code |
| wake_en_i | input | NUM_PINS | Allow events to latch the wake status |
| int_clr_i | input | NUM_PINS | Write-one-to-clear strobe for interrupt status |
| wake_clr_i | input | NUM_PINS | Write-one-to-clear strobe for wake status |
| out_val_i | input | NUM_PINS | Output value to drive |
| out_en_i | input | NUM_PINS | Output enable |
| pad_out_o | output | NUM_PINS | Value presented to the pad |
| pad_oe_o | output | NUM_PINS | Enable presented to the pad |
| pin_sts_o | output | NUM_PINS | Sampled input level, 0 while driving |
| int_sts_o | output | NUM_PINS | Sticky interrupt status |
| wake_sts_o | output | NUM_PINS | Sticky wake status |
| irq_o | output | NUM_PINS | Unmasked interrupt per pin |
| irq_any_o | output | 1 | OR of irq_o |
| wake_any_o | output | 1 | OR of wake_sts_o |

## Verification
An input or strobe applied in a cycle takes effect at the next rising edge. The interrupt status, wake status and pin status are all due there, one register stage after the stimulus. The interrupt outputs and pad outputs are combinational from their controls, so a mask or output-enable change is visible after that same edge. The driver applies each stimulus at the falling edge and queues one expected item for that cycle. The monitor compares it shortly after the following rising edge, so every comparison lands in the cycle its result is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Per-pin polarity / edge selection code
    typedef enum logic [1:0] {
        SEL_LOW_FALL  = 2'b00,
        SEL_HIGH_RISE = 2'b01,
        SEL_BOTH      = 2'b10,
        SEL_RSVD      = 2'b11
    } act_sel_e;

    localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 4,
    localparam int unsigned SELV_W  = NUM_PINS * SEL_W
) (
    input  logic [NUM_PINS-1:0] level_now_i,
    input  logic [NUM_PINS-1:0] level_prev_i,
    input  logic [NUM_PINS-1:0] trig_level_i,
    input  logic [SELV_W-1:0]   act_sel_i,
    output logic [NUM_PINS-1:0] evt_o
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        act_sel_e sel;
        logic     rise;
        logic     fall;

        always_comb begin
            sel  = act_sel_e'(act_sel_i[i*SEL_W +: SEL_W]);
            rise = level_now_i[i] & ~level_prev_i[i];
            fall = ~level_now_i[i] & level_prev_i[i];
            evt_o[i] = 1'b0;
            if (trig_level_i[i]) begin
                unique case (sel)
                    SEL_LOW_FALL:  evt_o[i] = ~level_now_i[i];
                    SEL_HIGH_RISE: evt_o[i] = level_now_i[i];
                    default:       evt_o[i] = 1'b0;
                endcase
            end else begin
                unique case (sel)
                    SEL_LOW_FALL:  evt_o[i] = fall;
                    SEL_HIGH_RISE: evt_o[i] = rise;
                    SEL_BOTH:      evt_o[i] = rise | fall;
                    default:       evt_o[i] = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_sts_core.sv
module gpio_sts_core #(
    parameter int unsigned NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level_i,
    input  logic [NUM_PINS-1:0] evt_i,
    input  logic [NUM_PINS-1:0] int_en_i,
    input  logic [NUM_PINS-1:0] wake_en_i,
    input  logic [NUM_PINS-1:0] int_clr_i,
    input  logic [NUM_PINS-1:0] wake_clr_i,
    output logic [NUM_PINS-1:0] pin_q_o,
    output logic [NUM_PINS-1:0] int_sts_o,
    output logic [NUM_PINS-1:0] wake_sts_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] pin;
        logic [NUM_PINS-1:0] int_sts;
        logic [NUM_PINS-1:0] wake_sts;
    } sts_state_t;

    sts_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pin = pin_level_i;
        for (int i = 0; i < NUM_PINS; i++) begin
            // a set in the same cycle outranks the clear strobe
            if (evt_i[i] && int_en_i[i]) begin
                st_d.int_sts[i] = 1'b1;
            end else if (int_clr_i[i]) begin
                st_d.int_sts[i] = 1'b0;
            end
            if (evt_i[i] && wake_en_i[i]) begin
                st_d.wake_sts[i] = 1'b1;
            end else if (wake_clr_i[i]) begin
                st_d.wake_sts[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_q_o    = st_q.pin;
    assign int_sts_o  = st_q.int_sts;
    assign wake_sts_o = st_q.wake_sts;

endmodule

// File: rtl/gpio_pad_path.sv
module gpio_pad_path #(
    parameter int unsigned NUM_PINS = 4
) (
    input  logic [NUM_PINS-1:0] out_val_i,
    input  logic [NUM_PINS-1:0] out_en_i,
    input  logic [NUM_PINS-1:0] pin_q_i,
    input  logic [NUM_PINS-1:0] int_sts_i,
    input  logic [NUM_PINS-1:0] int_unmask_i,
    input  logic [NUM_PINS-1:0] wake_sts_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pin_sts_o,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                irq_any_o,
    output logic                wake_any_o
);

    always_comb begin
        pad_oe_o   = out_en_i;
        pad_out_o  = out_val_i & out_en_i;
        pin_sts_o  = pin_q_i & ~out_en_i;
        irq_o      = int_sts_i & int_unmask_i;
        irq_any_o  = |irq_o;
        wake_any_o = |wake_sts_i;
    end

endmodule

// File: rtl/gpio_irq_pin_ctrl.sv
module gpio_irq_pin_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 4,
    localparam int unsigned SELV_W  = NUM_PINS * SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level_i,
    input  logic [NUM_PINS-1:0] int_en_i,
    input  logic [NUM_PINS-1:0] int_unmask_i,
    input  logic [NUM_PINS-1:0] trig_level_i,
    input  logic [SELV_W-1:0]   act_sel_i,
    input  logic [NUM_PINS-1:0] wake_en_i,
    input  logic [NUM_PINS-1:0] int_clr_i,
    input  logic [NUM_PINS-1:0] wake_clr_i,
    input  logic [NUM_PINS-1:0] out_val_i,
    input  logic [NUM_PINS-1:0] out_en_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pin_sts_o,
    output logic [NUM_PINS-1:0] int_sts_o,
    output logic [NUM_PINS-1:0] wake_sts_o,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                irq_any_o,
    output logic                wake_any_o
);

    logic [NUM_PINS-1:0] pin_q;
    logic [NUM_PINS-1:0] evt;

    gpio_evt_detect #(.NUM_PINS(NUM_PINS)) u_evt (
        .level_now_i  (pin_level_i),
        .level_prev_i (pin_q),
        .trig_level_i (trig_level_i),
        .act_sel_i    (act_sel_i),
        .evt_o        (evt)
    );

    gpio_sts_core #(.NUM_PINS(NUM_PINS)) u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_level_i (pin_level_i),
        .evt_i       (evt),
        .int_en_i    (int_en_i),
        .wake_en_i   (wake_en_i),
        .int_clr_i   (int_clr_i),
        .wake_clr_i  (wake_clr_i),
        .pin_q_o     (pin_q),
        .int_sts_o   (int_sts_o),
        .wake_sts_o  (wake_sts_o)
    );

    gpio_pad_path #(.NUM_PINS(NUM_PINS)) u_pad (
        .out_val_i    (out_val_i),
        .out_en_i     (out_en_i),
        .pin_q_i      (pin_q),
        .int_sts_i    (int_sts_o),
        .int_unmask_i (int_unmask_i),
        .wake_sts_i   (wake_sts_o),
        .pad_out_o    (pad_out_o),
        .pad_oe_o     (pad_oe_o),
        .pin_sts_o    (pin_sts_o),
        .irq_o        (irq_o),
        .irq_any_o    (irq_any_o),
        .wake_any_o   (wake_any_o)
    );

endmodule

// File: rtl/gpio_irq_pin_ctrl_chk.sv
module gpio_irq_pin_ctrl_chk #(
    parameter int unsigned NUM_PINS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pin_level_i,
    input logic [NUM_PINS-1:0]   int_en_i,
    input logic [NUM_PINS-1:0]   int_unmask_i,
    input logic [NUM_PINS-1:0]   trig_level_i,
    input logic [2*NUM_PINS-1:0] act_sel_i,
    input logic [NUM_PINS-1:0]   int_clr_i,
    input logic [NUM_PINS-1:0]   wake_clr_i,
    input logic [NUM_PINS-1:0]   int_sts_o,
    input logic [NUM_PINS-1:0]   wake_sts_o,
    input logic [NUM_PINS-1:0]   irq_o
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        AST_EN_GATES_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && !$past(int_en_i[i]) && !$past(int_sts_o[i])) |-> !int_sts_o[i]); // R6

        AST_INT_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(int_sts_o[i]) && !int_sts_o[i]) |-> $past(int_clr_i[i])); // R8

        AST_WAKE_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(wake_sts_o[i]) && !wake_sts_o[i]) |-> $past(wake_clr_i[i])); // R9

        AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(act_sel_i[2*i +: 2]) == 2'b11 && !$past(int_sts_o[i])
             && !$past(wake_sts_o[i])) |-> (!int_sts_o[i] && !wake_sts_o[i])); // R5

        AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(trig_level_i[i]) && $past(act_sel_i[2*i +: 2]) == 2'b01
             && $past(int_en_i[i]) && $past(pin_level_i[i])) |-> int_sts_o[i]); // R4

        AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            !int_unmask_i[i] |-> !irq_o[i]); // R7
    end

endmodule

bind gpio_irq_pin_ctrl gpio_irq_pin_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_level_i  (pin_level_i),
    .int_en_i     (int_en_i),
    .int_unmask_i (int_unmask_i),
    .trig_level_i (trig_level_i),
    .act_sel_i    (act_sel_i),
    .int_clr_i    (int_clr_i),
    .wake_clr_i   (wake_clr_i),
    .int_sts_o    (int_sts_o),
    .wake_sts_o   (wake_sts_o),
    .irq_o        (irq_o)
);

// File: tb/gpio_irq_pin_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_pin_ctrl_tb;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pin, en, unmask, trig, wen, iclr, wclr, ov, oe;
    logic [2*N-1:0] sel;
    logic [N-1:0] pad_out, pad_oe, psts, ists, wsts, irq;
    logic         irq_any, wake_any;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_pin_ctrl #(.NUM_PINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_level_i(pin), .int_en_i(en),
        .int_unmask_i(unmask), .trig_level_i(trig), .act_sel_i(sel),
        .wake_en_i(wen), .int_clr_i(iclr), .wake_clr_i(wclr),
        .out_val_i(ov), .out_en_i(oe), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .pin_sts_o(psts), .int_sts_o(ists), .wake_sts_o(wsts), .irq_o(irq),
        .irq_any_o(irq_any), .wake_any_o(wake_any)
    );

    typedef struct {
        bit           pad_kind;
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N-1:0] c;
        string        tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    exp_item_t cur;

    // monitor: compare one queued item per cycle, just after the rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            checks++;
            if (!cur.pad_kind) begin
                if (ists !== cur.a || wsts !== cur.b || irq !== cur.c ||
                    irq_any !== (|cur.c) || wake_any !== (|cur.b)) begin
                    errors++;
                    $display("FAIL %s: int=%b wake=%b irq=%b any=%b/%b expected int=%b wake=%b irq=%b any=%b/%b",
                             cur.tag, ists, wsts, irq, irq_any, wake_any,
                             cur.a, cur.b, cur.c, |cur.c, |cur.b);
                end
            end else begin
                if (pad_out !== cur.a || pad_oe !== cur.b || psts !== cur.c) begin
                    errors++;
                    $display("FAIL %s: pad_out=%b pad_oe=%b pin_sts=%b expected %b %b %b",
                             cur.tag, pad_out, pad_oe, psts, cur.a, cur.b, cur.c);
                end
            end
        end
    end

    task automatic cyc(input string tag, input logic [N-1:0] ei,
                       input logic [N-1:0] ew, input logic [N-1:0] eq);
        exp_item_t it;
        it.pad_kind = 1'b0; it.a = ei; it.b = ew; it.c = eq; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic padchk(input string tag, input logic [N-1:0] eo,
                          input logic [N-1:0] ee, input logic [N-1:0] es);
        exp_item_t it;
        it.pad_kind = 1'b1; it.a = eo; it.b = ee; it.c = es; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_sel(input int idx, input logic [1:0] v);
        sel[2*idx +: 2] = v;
    endtask

    initial begin
        rst_n = 1'b0; pin = '0; en = '1; unmask = '1; trig = '0; wen = '0;
        iclr = '0; wclr = '0; ov = '0; oe = '0; sel = 8'b01010101;
        repeat (2) @(negedge clk);
        cyc("R1 in reset", 4'b0000, 4'b0000, 4'b0000);
        rst_n = 1'b1;
        cyc("R1 after release", 4'b0000, 4'b0000, 4'b0000);

        // R2 rising edge, sticky
        pin = 4'b0001; cyc("R2 rise sets", 4'b0001, 4'b0000, 4'b0001);
        cyc("R2 sticky", 4'b0001, 4'b0000, 4'b0001);
        iclr = 4'b0001; cyc("R8 clear", 4'b0000, 4'b0000, 4'b0000); iclr = '0;

        // R8 writing zero leaves status
        pin = 4'b0011; cyc("R2 pin1 rise", 4'b0010, 4'b0000, 4'b0010);
        iclr = 4'b0001; cyc("R8 zero bit keeps", 4'b0010, 4'b0000, 4'b0010);
        iclr = 4'b0010; cyc("R8 clear pin1", 4'b0000, 4'b0000, 4'b0000); iclr = '0;

        // R3 falling and both edges
        set_sel(0, 2'b00);
        pin = 4'b0010; cyc("R3 fall sets", 4'b0001, 4'b0000, 4'b0001);
        iclr = 4'b0001; cyc("R3 clear", 4'b0000, 4'b0000, 4'b0000); iclr = '0;
        set_sel(2, 2'b10);
        pin = 4'b0110; cyc("R3 both rise", 4'b0100, 4'b0000, 4'b0100);
        iclr = 4'b0100; cyc("R3 clear", 4'b0000, 4'b0000, 4'b0000); iclr = '0;
        pin = 4'b0010; cyc("R3 both fall", 4'b0100, 4'b0000, 4'b0100);
        iclr = 4'b0100; cyc("R3 clear", 4'b0000, 4'b0000, 4'b0000); iclr = '0;

        // R8 set beats clear
        pin = 4'b1010; iclr = 4'b1000; cyc("R8 edge wins", 4'b1000, 4'b0000, 4'b1000);
        cyc("R8 plain clear", 4'b0000, 4'b0000, 4'b0000); iclr = '0;

        // R5 reserved codes
        set_sel(0, 2'b11);
        pin = 4'b1011; cyc("R5 rsvd rise", 4'b0000, 4'b0000, 4'b0000);
        pin = 4'b1010; cyc("R5 rsvd fall", 4'b0000, 4'b0000, 4'b0000);
        trig[0] = 1'b1; set_sel(0, 2'b10);
        pin = 4'b1011; cyc("R5 level both", 4'b0000, 4'b0000, 4'b0000);
        cyc("R5 level both held", 4'b0000, 4'b0000, 4'b0000);
        pin = 4'b1010; cyc("R5 level both low", 4'b0000, 4'b0000, 4'b0000);

        // R4 level mode
        set_sel(0, 2'b01); cyc("R4 high idle", 4'b0000, 4'b0000, 4'b0000);
        pin = 4'b1011; cyc("R4 high sets", 4'b0001, 4'b0000, 4'b0001);
        iclr = 4'b0001; cyc("R4 clear ineffective", 4'b0001, 4'b0000, 4'b0001); iclr = '0;
        pin = 4'b1010; cyc("R4 sticky after", 4'b0001, 4'b0000, 4'b0001);
        iclr = 4'b0001; cyc("R4 clear inactive", 4'b0000, 4'b0000, 4'b0000); iclr = '0;
        set_sel(0, 2'b00); cyc("R4 low sets", 4'b0001, 4'b0000, 4'b0001);
        pin = 4'b1011; cyc("R4 low sticky", 4'b0001, 4'b0000, 4'b0001);
        iclr = 4'b0001; cyc("R4 low clear", 4'b0000, 4'b0000, 4'b0000); iclr = '0;
        trig[0] = 1'b0; set_sel(0, 2'b01);
        cyc("R2 no edge", 4'b0000, 4'b0000, 4'b0000);

        // R6 enable gates latch
        en[1] = 1'b0;
        pin = 4'b1001; cyc("R6 fall", 4'b0000, 4'b0000, 4'b0000);
        pin = 4'b1011; cyc("R6 disabled rise", 4'b0000, 4'b0000, 4'b0000);
        en = '1; cyc("R6 no recovery", 4'b0000, 4'b0000, 4'b0000);
        pin = 4'b1001; cyc("R6 fall", 4'b0000, 4'b0000, 4'b0000);
        pin = 4'b1011; cyc("R6 enabled rise", 4'b0010, 4'b0000, 4'b0010);
        iclr = 4'b0010; cyc("R6 clear", 4'b0000, 4'b0000, 4'b0000); iclr = '0;

        // R7 mask
        unmask[1] = 1'b0;
        pin = 4'b1001; cyc("R7 fall", 4'b0000, 4'b0000, 4'b0000);
        pin = 4'b1011; cyc("R7 masked latch", 4'b0010, 4'b0000, 4'b0000);
        unmask = '1; cyc("R7 unmask shows", 4'b0010, 4'b0000, 4'b0010);
        iclr = 4'b0010; cyc("R7 clear", 4'b0000, 4'b0000, 4'b0000); iclr = '0;

        // R9 wake status
        en[2] = 1'b0; wen = 4'b0100;
        pin = 4'b1111; cyc("R9 wake set", 4'b0000, 4'b0100, 4'b0000);
        iclr = 4'b0100; cyc("R9 int clear no effect", 4'b0000, 4'b0100, 4'b0000); iclr = '0;
        wclr = 4'b0100; cyc("R9 wake clear", 4'b0000, 4'b0000, 4'b0000);
        pin = 4'b1011; cyc("R9 edge beats clear", 4'b0000, 4'b0100, 4'b0000);
        cyc("R9 wake clear again", 4'b0000, 4'b0000, 4'b0000);
        wclr = '0; en = '1; wen = '0;

        // R10 pad path
        oe = 4'b0101; ov = 4'b0011;
        padchk("R10 pad a", 4'b0001, 4'b0101, 4'b1010);
        oe = 4'b1010; ov = 4'b1100;
        padchk("R10 pad b", 4'b1000, 4'b1010, 4'b0001);

        @(posedge clk); #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule